// File: doc/BRIEF.md
# Audio Control Register Write Port

This block is the control-bus front end of a multi-function audio processor. A host writes settings into it over a two-wire serial bus, using the standard I2C write framing. The block oversamples SCL and SDA with the system clock and recognises START and STOP conditions. It accepts the chip address byte and then a subaddress byte. After that it stores each data byte into a bank of ten 8-bit configuration registers. The register contents leave the block as one flat parallel bus that the analog control logic decodes.

The subaddress byte chooses between two write patterns. If its top bit is clear, every data byte up to the STOP lands in the same register. If its top bit is set, the target steps forward by one after each byte. The target pointer is 4 bits wide and wraps from 15 to 0. Slots 10 to 15 hold no register, so bytes aimed at them are acknowledged and then dropped. The block only ever writes: it acknowledges by pulling SDA low through an open-drain enable, and it never stretches the clock.

Top module: `ctlbus_wr_slave`

## Requirements
- R1: After reset the register bank holds these defaults: register 0 = 0x3F, register 1 = 0x7E, register 2 = 0x00, register 3 = 0x1F, register 4 = 0xFF, registers 5 to 8 = 0x60, register 9 = 0x06. The SDA drive enable is low after reset.
- R2: After a START, the byte 0x80 (address 0x40 with a write bit) is acknowledged. The drive enable rises after the falling SCL edge that ends bit 8, stays high through the ninth clock, and falls after the falling SCL edge that ends that clock.
- R3: Any other first byte is not acknowledged, including 0x81 (a read request). The slave then neither acknowledges nor writes anything until the next START.
- R4: The byte after a matched address is acknowledged. Its bit 7 is the step flag, bits 6 to 4 are ignored, and bits 3 to 0 give the starting register.
- R5: With the step flag clear, each data byte is acknowledged and overwrites the selected register, so the last byte before STOP remains.
- R6: With the step flag set, each data byte goes to the current pointer and the pointer then advances by one, wrapping from 15 to 0.
- R7: A data byte aimed at pointer 10 to 15 is acknowledged but changes no register.
- R8: A register changes only after all 8 bits of a data byte have arrived. A byte cut short by STOP or START writes nothing.
- R9: A repeated START in the middle of a transfer restarts address reception, and a new subaddress and new data are then accepted.
- R10: The drive enable only rises while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line level (asynchronous) |
| sda_in | input | 1 | Serial data line level (asynchronous) |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| cfg_regs | output | 80 | Register bank, register n on bits [8n+7:8n] |

## Verification
The write patterns tell the two subaddress modes apart. A same-register burst must leave only its last byte. A stepping burst starting at register 8 must fill 8 and 9, skip 10 to 15 and land on 0. A burst of eighteen bytes must wrap twice over the low registers. Setting the don't-care subaddress bits and writing to unimplemented slot 12 show which subaddress bits select the register. Wrong addresses, a read request, a truncated byte and a repeated START cut short partway through separate the acknowledge decision from the register commit.

// File: rtl/ctlbus_pkg.sv
// Package: shared types and reset constants for the control-bus write port.
// Assumes: register widths of 8 bits; reset values match the analog decoders.
package ctlbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_DATA,
        ST_SKIP
    } frame_st_t;

    typedef enum logic [1:0] {
        ACK_NONE,
        ACK_ARM,
        ACK_HOLD
    } ack_ph_t;

    // Reset code of each register: maximum input and effect attenuation,
    // surround off with fixed output, tone flat, outputs muted, first input.
    function automatic logic [7:0] reset_value(input int idx);
        logic [7:0] v;
        case (idx)
            0:       v = 8'h3F;
            1:       v = 8'h7E;
            3:       v = 8'h1F;
            4:       v = 8'hFF;
            5, 6, 7, 8: v = 8'h60;
            9:       v = 8'h06;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/bus_sampler.sv
// Module: bus_sampler
// Brings SCL and SDA into the clock domain through a synchroniser chain and
// flags SCL edges and START/STOP conditions, one cycle wide each.
// Assumes: the bus is idle-high and each line holds a level for several clocks.
module bus_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    // Synchroniser chains, reset to the idle-high bus level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
        end
    end

    assign scl_lvl = scl_pipe[STAGES-1];
    assign sda_lvl = sda_pipe[STAGES-1];

    // Previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/frame_ctrl.sv
// Module: frame_ctrl
// Runs the write-frame protocol: shifts bits on SCL rise, checks the chip
// address, latches the subaddress and step flag, issues one write per data
// byte and drives the acknowledge slot.
// Assumes: edge and condition strobes come from bus_sampler.
module frame_ctrl
    import ctlbus_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h40,
    parameter int         BYTE_W   = 8,
    parameter int         PTR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    frame_st_t         state;
    ack_ph_t           ack_ph;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [PTR_W-1:0]  ptr;
    logic              step_en;
    logic [BYTE_W-1:0] byte_in;

    // Byte as it stands once the current bit is shifted in.
    assign byte_in = {shreg[BYTE_W-2:0], sda_lvl};

    // Protocol sequencer, bit counter, acknowledge slot and write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ack_ph  <= ACK_NONE;
            bit_cnt <= '0;
            shreg   <= '0;
            ptr     <= '0;
            step_en <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                ack_ph  <= ACK_NONE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                ack_ph <= ACK_NONE;
                sda_oe <= 1'b0;
            end else if (state == ST_ADDR || state == ST_SUB || state == ST_DATA) begin
                case (ack_ph)
                    ACK_NONE: begin
                        if (scl_rise) begin
                            shreg <= byte_in;
                            if (bit_cnt == LAST_BIT) begin
                                bit_cnt <= '0;
                                ack_ph  <= ACK_ARM;
                                case (state)
                                    ST_ADDR: begin
                                        if (byte_in == {DEV_ADDR, 1'b0}) begin
                                            state <= ST_SUB;
                                        end else begin
                                            state  <= ST_SKIP;
                                            ack_ph <= ACK_NONE;
                                        end
                                    end
                                    ST_SUB: begin
                                        step_en <= byte_in[BYTE_W-1];
                                        ptr     <= byte_in[PTR_W-1:0];
                                        state   <= ST_DATA;
                                    end
                                    default: begin
                                        wr_en   <= 1'b1;
                                        wr_addr <= ptr;
                                        wr_data <= byte_in;
                                        if (step_en) begin
                                            ptr <= ptr + 1'b1;
                                        end
                                    end
                                endcase
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ACK_ARM: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b1;
                            ack_ph <= ACK_HOLD;
                        end
                    end
                    default: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            ack_ph <= ACK_NONE;
                        end
                    end
                endcase
            end
        end
    end

    // R10: the acknowledge pull-down starts only while SCL is low.
    a_r10_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

    // R2: a STOP always returns the sequencer to idle.
    a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    // R3: an unaddressed slave never pulls SDA.
    a_r3_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !sda_oe);

    // R8: a write strobe follows the SCL rise that completed a byte.
    a_r8_write_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(scl_rise));

endmodule

// File: rtl/cfg_reg_bank.sv
// Module: cfg_reg_bank
// Holds the configuration registers, loads their reset codes and takes one
// write per strobe; writes to slots beyond the bank are dropped.
// Assumes: wr_addr may name any pointer value, including empty slots.
module cfg_reg_bank
    import ctlbus_pkg::*;
#(
    parameter int NUM_REGS = 10,
    parameter int REG_W    = 8,
    parameter int PTR_W    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [PTR_W-1:0]          wr_addr,
    input  logic [REG_W-1:0]          wr_data,
    output logic [NUM_REGS*REG_W-1:0] regs_flat
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [REG_W-1:0] value;

        // One register: reset code, then load on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                value <= REG_W'(reset_value(g));
            end else if (wr_en && (wr_addr == PTR_W'(g))) begin
                value <= wr_data;
            end
        end

        assign regs_flat[g*REG_W +: REG_W] = value;
    end

    // R7: a write to an empty slot leaves the whole bank unchanged.
    a_r7_empty_slot_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_addr) >= NUM_REGS)) |=> $stable(regs_flat));

endmodule

// File: rtl/ctlbus_wr_slave.sv
// Module: ctlbus_wr_slave
// Top of the write-only control-bus port: sampler, frame sequencer and
// register bank. The pad uses sda_oe to pull SDA low.
// Assumes: SCL runs at least ten times slower than clk.
module ctlbus_wr_slave
    import ctlbus_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h40,
    parameter int         NUM_REGS = 10,
    parameter int         REG_W    = 8,
    parameter int         PTR_W    = 4,
    parameter int         STAGES   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_in,
    input  logic                      sda_in,
    output logic                      sda_oe,
    output logic [NUM_REGS*REG_W-1:0] cfg_regs
);
    logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic [REG_W-1:0] wr_data;

    bus_sampler #(.STAGES(STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    frame_ctrl #(.DEV_ADDR(DEV_ADDR), .BYTE_W(REG_W), .PTR_W(PTR_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    cfg_reg_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .PTR_W(PTR_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .regs_flat (cfg_regs)
    );

endmodule

// File: tb/ctlbus_wr_slave_bench.sv
// Bench: a bus-master driver updates a register model and pushes expected
// bank snapshots into a queue; a monitor pops and compares them to cfg_regs.
module ctlbus_wr_slave_bench;
    localparam int NREG = 10;
    localparam int Q    = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [79:0] cfg_regs;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0]  mdl [NREG];
    logic [79:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    ctlbus_wr_slave u_ctlbus_wr_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl),
        .sda_in   (sda_line),
        .sda_oe   (sda_oe),
        .cfg_regs (cfg_regs)
    );

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [79:0] model_flat();
        logic [79:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = mdl[i];
        return v;
    endfunction

    task automatic push_expect(input string tag);
        wait_clks(4);
        exp_q.push_back(model_flat());
        tag_q.push_back(tag);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clks(Q);
        scl = 1'b1;   wait_clks(Q);
        sda_m = 1'b0; wait_clks(Q);
        scl = 1'b0;   wait_clks(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clks(Q);
        scl = 1'b1;   wait_clks(Q);
        sda_m = 1'b1; wait_clks(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;  wait_clks(Q);
        scl = 1'b1; wait_clks(Q);
        scl = 1'b0; wait_clks(Q);
    endtask

    // Eight bits MSB first, then the ninth clock with acknowledge checks.
    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wait_clks(Q);
        scl = 1'b1;   wait_clks(Q/2);
        check({req, " ack"}, {79'd0, sda_oe}, {79'd0, exp_ack});
        wait_clks(Q/2);
        scl = 1'b0;   wait_clks(Q);
        check("R10 release", {79'd0, sda_oe}, 80'd0);
    endtask

    // One write frame with the model updated per the step/skip rules.
    task automatic write_txn(input logic [7:0] sub, input logic [7:0] d [20], input int n, input string req);
        logic [3:0] p;
        p = sub[3:0];
        bus_start();
        send_byte(8'h80, 1'b1, "R2");
        send_byte(sub, 1'b1, "R4");
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], 1'b1, req);
            if (int'(p) < NREG) mdl[p] = d[i];
            if (sub[7]) p = p + 4'd1;
        end
        bus_stop();
        push_expect(req);
    endtask

    // Monitor: compares each queued snapshot with the register outputs.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                logic [79:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, cfg_regs, e);
            end
        end
    end

    initial begin
        repeat (200000) @(negedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d [20];
        mdl[0] = 8'h3F; mdl[1] = 8'h7E; mdl[2] = 8'h00; mdl[3] = 8'h1F; mdl[4] = 8'hFF;
        mdl[5] = 8'h60; mdl[6] = 8'h60; mdl[7] = 8'h60; mdl[8] = 8'h60; mdl[9] = 8'h06;
        for (int i = 0; i < 20; i++) d[i] = 8'h00;
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(5);

        // R1: reset defaults and idle drive enable.
        check("R1 oe", {79'd0, sda_oe}, 80'd0);
        push_expect("R1 defaults");

        // R5: same-register burst keeps the last byte.
        d[0] = 8'hA5; d[1] = 8'h5A; d[2] = 8'hC3;
        write_txn(8'h03, d, 3, "R5");

        // R6/R7: stepping burst from 8 skips 10..15 and wraps to 0.
        for (int i = 0; i < 9; i++) d[i] = 8'h10 + 8'(i);
        write_txn(8'h88, d, 9, "R7");

        // R4: don't-care bits 6:4 set, stepping from 1.
        d[0] = 8'h21; d[1] = 8'h22;
        write_txn(8'hF1, d, 2, "R4");

        // R7: fixed write to empty slot 12 changes nothing.
        d[0] = 8'hEE; d[1] = 8'hDD;
        write_txn(8'h0C, d, 2, "R7");

        // R6: long burst wraps the pointer twice past register 0 and 1.
        for (int i = 0; i < 18; i++) d[i] = 8'h40 + 8'(i);
        write_txn(8'h80, d, 18, "R6");

        // R3: wrong address, later bytes neither acked nor written.
        bus_start();
        send_byte(8'h82, 1'b0, "R3");
        send_byte(8'h05, 1'b0, "R3");
        send_byte(8'h77, 1'b0, "R3");
        bus_stop();
        push_expect("R3 wrong address");

        // R3: read request is not acknowledged.
        bus_start();
        send_byte(8'h81, 1'b0, "R3");
        send_byte(8'h02, 1'b0, "R3");
        bus_stop();
        push_expect("R3 read request");

        // R8: byte cut short by STOP writes nothing.
        bus_start();
        send_byte(8'h80, 1'b1, "R2");
        send_byte(8'h06, 1'b1, "R4");
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
        bus_stop();
        push_expect("R8 partial byte");

        // R9: repeated START after a partial byte restarts the frame.
        bus_start();
        send_byte(8'h80, 1'b1, "R2");
        send_byte(8'h07, 1'b1, "R4");
        send_byte(8'h44, 1'b1, "R5");
        mdl[7] = 8'h44;
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        send_byte(8'h80, 1'b1, "R9");
        send_byte(8'h85, 1'b1, "R9");
        send_byte(8'h99, 1'b1, "R9");
        send_byte(8'hAB, 1'b1, "R9");
        mdl[5] = 8'h99; mdl[6] = 8'hAB;
        bus_stop();
        push_expect("R9 repeated start");

        wait_clks(10);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule